// File: doc/BRIEF.md
# SPI SD Card Block Reader

This block is a host controller that talks to a standard-capacity SD card in SPI mode. It produces the serial clock, the command line and the active-low chip select from a system clock, and it samples the card's data-out line. After reset it waits until an initialization pulse arrives. It then runs the power-up and bring-up sequence and reports either ready or error.

Once the block is ready, a start pulse reads one 512-byte block, chosen by block number, into an internal buffer. Any stored byte can then be looked up through a byte-index port. Standard-capacity cards take a byte address, so the read command carries the block number multiplied by 512.

An initialization pulse can be given at any time. It abandons whatever the block is doing, clears the status and starts the card up again. This is also how the block recovers after an error.

Top module: `sdblk_reader`

## Requirements
- R1: After reset `sd_cs_n` is high, `sd_sck` is low, and `ready` and `error` are both low. The serial clock stays still until `init_req` is pulsed.
- R2: After `init_req`, at least 74 serial clock cycles run with `sd_cs_n` and `sd_mosi` both high. The first command frame is then the six bytes 0x40 0x00 0x00 0x00 0x00 0x95.
- R3: A reply to the reset command other than 0x01 sets `error`.
- R4: Bring-up repeats the pair CMD55 (first byte 0x77) then CMD41 (first byte 0x69) while CMD41 replies 0x01. A reply of 0x00 sets `ready`. If the reply is still 0x01 after ACMD_TRIES attempts, `error` is set. `ready` and `error` are never high together.
- R5: After each command the block polls for a reply by clocking 0xFF bytes. It accepts the first byte whose bit 7 is 0, and it gives up with `error` after 8 bytes.
- R6: The serial interface runs in SPI mode 0. SCK idles low, and each SCK high phase lasts CLK_DIV system clocks. MOSI changes only while SCK is low. MOSI is sent MSB first, and MISO is sampled on the rising edge.
- R7: `rd_start` is accepted only while `ready` is high and is ignored otherwise. An accepted start sends 0x51, then the 32-bit argument `blk_num`×512 MSB first, then 0x01.
- R8: `ready` drops on the cycle after a read is accepted. The block waits for the token 0xFE, stores the 512 data bytes that follow, discards two CRC bytes and raises `ready` again. `byte_out` shows the stored byte at `byte_idx` one clock after `byte_idx` is applied.
- R9: During a read, `error` is set in two cases: a token byte that is neither 0xFF nor 0xFE, or no 0xFE within TOKEN_POLL bytes.
- R10: `init_req` at any time clears `ready` and `error` on the next clock and restarts the whole bring-up sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| init_req | input | 1 | One-cycle pulse that starts (or restarts) card bring-up |
| rd_start | input | 1 | One-cycle pulse that starts a block read |
| blk_num | input | BLK_W | Block number to read |
| byte_idx | input | 9 | Byte offset into the stored block |
| byte_out | output | 8 | Stored byte at `byte_idx`, registered |
| ready | output | 1 | Card is initialized and idle |
| error | output | 1 | The last bring-up or read failed |
| sd_sck | output | 1 | SPI serial clock |
| sd_mosi | output | 1 | SPI data to the card |
| sd_miso | input | 1 | SPI data from the card |
| sd_cs_n | output | 1 | SPI chip select, active low |

## Verification
The bench drives a behavioural card that can vary its reply latency, reset reply, busy count, token delay and token value. Several boundaries are tested:
- A reply on the 8th poll byte must be accepted and one on the 9th must fail. A design with the poll bound off by one hangs or reports a false error.
- The read argument is checked at the highest block number. A shift or width mistake would send the wrong byte address.
- A card that stays busy for all ACMD_TRIES attempts must end in an error, where a faulty design would loop forever.
- An error token and a token timeout must both raise error without raising ready.
- A restart in the middle of a read must clear status at once and bring the card up cleanly. Every clock the bench also checks the SCK high time, MOSI stability while SCK is high, and that ready and error are never high together.

// File: rtl/sdblk_pkg.sv
package sdblk_pkg;

  localparam int BLOCK_BYTES = 512;
  localparam int IDX_W       = $clog2(BLOCK_BYTES);

  localparam logic [7:0] IDLE_BYTE  = 8'hFF;
  localparam logic [7:0] R1_IDLE    = 8'h01;
  localparam logic [7:0] R1_OK      = 8'h00;
  localparam logic [7:0] DATA_TOKEN = 8'hFE;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PWRUP, ST_CMD, ST_RESP, ST_TOKEN, ST_DATA, ST_CRC, ST_GAP
  } seq_st_e;

  typedef enum logic [1:0] {
    K_RESET, K_APPCMD, K_OPCOND, K_READ
  } cmd_e;

  function automatic logic [5:0] cmd_index(cmd_e c);
    case (c)
      K_RESET:  return 6'd0;
      K_APPCMD: return 6'd55;
      K_OPCOND: return 6'd41;
      default:  return 6'd17;
    endcase
  endfunction

  // One byte of the six-byte command frame, k = 0 is sent first.
  function automatic logic [7:0] frame_byte(cmd_e c, logic [31:0] arg, logic [2:0] k);
    case (k)
      3'd0:    return {2'b01, cmd_index(c)};
      3'd1:    return arg[31:24];
      3'd2:    return arg[23:16];
      3'd3:    return arg[15:8];
      3'd4:    return arg[7:0];
      default: return (c == K_RESET) ? 8'h95 : 8'h01;
    endcase
  endfunction

endpackage

// File: rtl/sdblk_shift.sv
module sdblk_shift #(
  parameter int CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       abort,
  input  logic       start,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx
);

  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic             active;
  logic [DIV_W-1:0] div;
  logic [2:0]       bitc;
  logic [7:0]       tsh;
  logic [7:0]       rsh;
  logic             tick;

  assign tick = (div == DIV_W'(CLK_DIV - 1));

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (rst || abort) begin
      active <= 1'b0;
      sck    <= 1'b0;
      mosi   <= 1'b1;
      div    <= '0;
      bitc   <= '0;
      tsh    <= 8'hFF;
      rsh    <= '0;
      rx     <= '0;
    end else if (!active) begin
      if (start) begin
        active <= 1'b1;
        tsh    <= tx;
        mosi   <= tx[7];
        bitc   <= '0;
        div    <= '0;
      end
    end else if (!tick) begin
      div <= div + 1'b1;
    end else begin
      div <= '0;
      if (!sck) begin
        sck <= 1'b1;
        rsh <= {rsh[6:0], miso};
      end else begin
        sck <= 1'b0;
        if (bitc == 3'd7) begin
          active <= 1'b0;
          done   <= 1'b1;
          rx     <= rsh;
          mosi   <= 1'b1;
        end else begin
          bitc <= bitc + 1'b1;
          tsh  <= {tsh[6:0], 1'b1};
          mosi <= tsh[6];
        end
      end
    end
  end

  AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (rst)
    (sck && $past(sck)) |-> $stable(mosi)) else $error("mosi moved while sck high"); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done) else $error("done longer than one cycle"); // R6
  AST_SCK_REST: assert property (@(posedge clk) disable iff (rst)
    (!active && !start) |=> !sck) else $error("sck moved while idle"); // R1

endmodule

// File: rtl/sdblk_ram.sv
module sdblk_ram #(
  parameter int DW = 8,
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/sdblk_seq.sv
module sdblk_seq
  import sdblk_pkg::*;
#(
  parameter int BLK_W       = 23,
  parameter int INIT_CLOCKS = 80,
  parameter int RESP_POLL   = 8,
  parameter int ACMD_TRIES  = 1000,
  parameter int TOKEN_POLL  = 4096
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init_req,
  input  logic             rd_start,
  input  logic [BLK_W-1:0] blk_num,
  output logic             eng_start,
  output logic [7:0]       eng_tx,
  input  logic             eng_done,
  input  logic [7:0]       eng_rx,
  output logic             ram_we,
  output logic [IDX_W-1:0] ram_addr,
  output logic [7:0]       ram_wdata,
  output logic             ready,
  output logic             error,
  output logic             cs_n
);

  localparam int INIT_BYTES = (INIT_CLOCKS + 7) / 8;
  localparam int CNT_MAX0   = (BLOCK_BYTES > TOKEN_POLL) ? BLOCK_BYTES : TOKEN_POLL;
  localparam int CNT_MAX    = (CNT_MAX0 > INIT_BYTES) ? CNT_MAX0 : INIT_BYTES;
  localparam int CNT_W      = $clog2(CNT_MAX + 1);
  localparam int TRY_W      = $clog2(ACMD_TRIES + 1);

  seq_st_e          st;
  seq_st_e          after_st;
  cmd_e             cmd;
  cmd_e             after_cmd;
  logic [CNT_W-1:0] cnt;
  logic [TRY_W-1:0] tries;
  logic [BLK_W-1:0] blk_q;
  logic             inflight;
  logic [31:0]      arg;

  assign arg = (cmd == K_READ) ? 32'({blk_q, {IDX_W{1'b0}}}) : 32'd0;

  always_ff @(posedge clk) begin
    eng_start <= 1'b0;
    ram_we    <= 1'b0;
    if (rst) begin
      st        <= ST_IDLE;
      after_st  <= ST_IDLE;
      cmd       <= K_RESET;
      after_cmd <= K_RESET;
      cnt       <= '0;
      tries     <= '0;
      blk_q     <= '0;
      inflight  <= 1'b0;
      eng_tx    <= IDLE_BYTE;
      ram_addr  <= '0;
      ram_wdata <= '0;
      ready     <= 1'b0;
      error     <= 1'b0;
      cs_n      <= 1'b1;
    end else if (init_req) begin
      st       <= ST_PWRUP;
      cnt      <= '0;
      tries    <= '0;
      inflight <= 1'b0;
      ready    <= 1'b0;
      error    <= 1'b0;
      cs_n     <= 1'b1;
    end else if (st == ST_IDLE) begin
      if (rd_start && ready) begin
        ready <= 1'b0;
        blk_q <= blk_num;
        cmd   <= K_READ;
        cnt   <= '0;
        st    <= ST_CMD;
        cs_n  <= 1'b0;
      end
    end else if (!inflight) begin
      eng_start <= 1'b1;
      eng_tx    <= (st == ST_CMD) ? frame_byte(cmd, arg, cnt[2:0]) : IDLE_BYTE;
      inflight  <= 1'b1;
    end else if (eng_done) begin
      inflight <= 1'b0;
      case (st)
        ST_PWRUP: begin
          if (cnt == CNT_W'(INIT_BYTES - 1)) begin
            st <= ST_CMD; cmd <= K_RESET; cnt <= '0; cs_n <= 1'b0;
          end else cnt <= cnt + 1'b1;
        end
        ST_CMD: begin
          if (cnt == CNT_W'(5)) begin st <= ST_RESP; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        ST_RESP: begin
          if (eng_rx[7]) begin
            if (cnt == CNT_W'(RESP_POLL - 1)) begin
              error <= 1'b1; cs_n <= 1'b1; st <= ST_GAP; after_st <= ST_IDLE;
            end else cnt <= cnt + 1'b1;
          end else begin
            case (cmd)
              K_RESET: begin
                if (eng_rx == R1_IDLE) begin
                  st <= ST_GAP; cs_n <= 1'b1; after_st <= ST_CMD; after_cmd <= K_APPCMD;
                end else begin
                  error <= 1'b1; cs_n <= 1'b1; st <= ST_GAP; after_st <= ST_IDLE;
                end
              end
              K_APPCMD: begin
                if ((eng_rx & 8'hFE) == 8'h00) begin
                  st <= ST_GAP; cs_n <= 1'b1; after_st <= ST_CMD; after_cmd <= K_OPCOND;
                end else begin
                  error <= 1'b1; cs_n <= 1'b1; st <= ST_GAP; after_st <= ST_IDLE;
                end
              end
              K_OPCOND: begin
                if (eng_rx == R1_OK) begin
                  st <= ST_GAP; cs_n <= 1'b1; after_st <= ST_IDLE;
                end else if (eng_rx == R1_IDLE && tries != TRY_W'(ACMD_TRIES - 1)) begin
                  tries <= tries + 1'b1;
                  st <= ST_GAP; cs_n <= 1'b1; after_st <= ST_CMD; after_cmd <= K_APPCMD;
                end else begin
                  error <= 1'b1; cs_n <= 1'b1; st <= ST_GAP; after_st <= ST_IDLE;
                end
              end
              default: begin
                if (eng_rx == R1_OK) begin
                  st <= ST_TOKEN; cnt <= '0;
                end else begin
                  error <= 1'b1; cs_n <= 1'b1; st <= ST_GAP; after_st <= ST_IDLE;
                end
              end
            endcase
          end
        end
        ST_TOKEN: begin
          if (eng_rx == DATA_TOKEN) begin
            st <= ST_DATA; cnt <= '0;
          end else if (eng_rx == IDLE_BYTE && cnt != CNT_W'(TOKEN_POLL - 1)) begin
            cnt <= cnt + 1'b1;
          end else begin
            error <= 1'b1; cs_n <= 1'b1; st <= ST_GAP; after_st <= ST_IDLE;
          end
        end
        ST_DATA: begin
          ram_we    <= 1'b1;
          ram_addr  <= cnt[IDX_W-1:0];
          ram_wdata <= eng_rx;
          if (cnt == CNT_W'(BLOCK_BYTES - 1)) begin st <= ST_CRC; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        ST_CRC: begin
          if (cnt == CNT_W'(1)) begin
            st <= ST_GAP; cs_n <= 1'b1; after_st <= ST_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        default: begin
          st  <= after_st;
          cnt <= '0;
          if (after_st == ST_CMD) begin
            cmd  <= after_cmd;
            cs_n <= 1'b0;
          end else if (!error) begin
            ready <= 1'b1;
          end
        end
      endcase
    end
  end

  AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(ready && error)) else $error("ready and error both high"); // R4
  AST_CS_AT_REST: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> cs_n) else $error("cs asserted while idle"); // R1
  AST_PWRUP_DESELECT: assert property (@(posedge clk) disable iff (rst)
    (st == ST_PWRUP) |-> cs_n) else $error("cs asserted during power-up"); // R2
  AST_READ_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && ready && rd_start && !init_req) |=> !ready) else $error("ready kept during read"); // R8
  AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    init_req |=> (!ready && !error && st == ST_PWRUP)) else $error("init did not restart"); // R10
  AST_STORE_IN_DATA: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> ($past(st) == ST_DATA)) else $error("buffer written outside data phase"); // R8

endmodule

// File: rtl/sdblk_reader.sv
module sdblk_reader
  import sdblk_pkg::*;
#(
  parameter int CLK_DIV     = 4,
  parameter int BLK_W       = 23,
  parameter int INIT_CLOCKS = 80,
  parameter int RESP_POLL   = 8,
  parameter int ACMD_TRIES  = 1000,
  parameter int TOKEN_POLL  = 4096
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init_req,
  input  logic             rd_start,
  input  logic [BLK_W-1:0] blk_num,
  input  logic [IDX_W-1:0] byte_idx,
  output logic [7:0]       byte_out,
  output logic             ready,
  output logic             error,
  output logic             sd_sck,
  output logic             sd_mosi,
  input  logic             sd_miso,
  output logic             sd_cs_n
);

  logic             eng_start;
  logic [7:0]       eng_tx;
  logic             eng_done;
  logic [7:0]       eng_rx;
  logic             ram_we;
  logic [IDX_W-1:0] ram_addr;
  logic [7:0]       ram_wdata;

  sdblk_seq #(
    .BLK_W       (BLK_W),
    .INIT_CLOCKS (INIT_CLOCKS),
    .RESP_POLL   (RESP_POLL),
    .ACMD_TRIES  (ACMD_TRIES),
    .TOKEN_POLL  (TOKEN_POLL)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .init_req  (init_req),
    .rd_start  (rd_start),
    .blk_num   (blk_num),
    .eng_start (eng_start),
    .eng_tx    (eng_tx),
    .eng_done  (eng_done),
    .eng_rx    (eng_rx),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata),
    .ready     (ready),
    .error     (error),
    .cs_n      (sd_cs_n)
  );

  sdblk_shift #(
    .CLK_DIV (CLK_DIV)
  ) u_shift (
    .clk   (clk),
    .rst   (rst),
    .abort (init_req),
    .start (eng_start),
    .tx    (eng_tx),
    .miso  (sd_miso),
    .sck   (sd_sck),
    .mosi  (sd_mosi),
    .done  (eng_done),
    .rx    (eng_rx)
  );

  sdblk_ram #(
    .DW (8),
    .AW (IDX_W)
  ) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_addr),
    .wdata (ram_wdata),
    .raddr (byte_idx),
    .rdata (byte_out)
  );

endmodule

// File: tb/sdblk_reader_tb.sv
module sdblk_reader_tb;

  localparam int CLK_DIV    = 2;
  localparam int BLK_W      = 23;
  localparam int ACMD_TRIES = 4;
  localparam int TOKEN_POLL = 16;

  logic             clk = 1'b0;
  logic             rst;
  logic             init_req;
  logic             rd_start;
  logic [BLK_W-1:0] blk_num;
  logic [8:0]       byte_idx;
  logic [7:0]       byte_out;
  logic             ready;
  logic             error;
  logic             sd_sck;
  logic             sd_mosi;
  logic             sd_miso = 1'b1;
  logic             sd_cs_n;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  sdblk_reader #(
    .CLK_DIV    (CLK_DIV),
    .BLK_W      (BLK_W),
    .ACMD_TRIES (ACMD_TRIES),
    .TOKEN_POLL (TOKEN_POLL)
  ) u_dut (
    .clk      (clk),
    .rst      (rst),
    .init_req (init_req),
    .rd_start (rd_start),
    .blk_num  (blk_num),
    .byte_idx (byte_idx),
    .byte_out (byte_out),
    .ready    (ready),
    .error    (error),
    .sd_sck   (sd_sck),
    .sd_mosi  (sd_mosi),
    .sd_miso  (sd_miso),
    .sd_cs_n  (sd_cs_n)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural card ----------------
  int          ncr0    = 1;
  logic [7:0]  resp0   = 8'h01;
  int          busy_n  = 0;
  int          acmd_n  = 0;
  logic [7:0]  tok     = 8'hFE;
  int          tok_dly = 2;
  logic [7:0]  out_q[$];
  logic [47:0] cmd_log[$];
  logic [7:0]  cur = 8'hFF;
  logic [7:0]  rxb = 8'h00;
  int          bitn = 0;
  bit          in_frame = 0;
  int          fcnt = 0;
  logic [47:0] frame = '0;
  int          sck_rises = 0;
  int          pre_cnt = 0;
  int          pre_at_cs = 0;
  bit          first_cs = 0;

  function automatic logic [7:0] pat(logic [31:0] blk, int i);
    return 8'((i * 7) + (blk * 13) + 5);
  endfunction

  task automatic card_cmd(input logic [47:0] f);
    logic [31:0] a;
    cmd_log.push_back(f);
    a = f[39:8];
    case (f[45:40])
      6'd0: begin
        acmd_n = 0;
        repeat (ncr0) out_q.push_back(8'hFF);
        out_q.push_back(resp0);
      end
      6'd55: begin out_q.push_back(8'hFF); out_q.push_back(8'h01); end
      6'd41: begin
        out_q.push_back(8'hFF);
        out_q.push_back((acmd_n < busy_n) ? 8'h01 : 8'h00);
        acmd_n++;
      end
      6'd17: begin
        out_q.push_back(8'hFF);
        out_q.push_back(8'h00);
        repeat (tok_dly) out_q.push_back(8'hFF);
        out_q.push_back(tok);
        if (tok == 8'hFE) begin
          for (int i = 0; i < 512; i++) out_q.push_back(pat(a >> 9, i));
          out_q.push_back(8'hA5);
          out_q.push_back(8'h5A);
        end
      end
      default: out_q.push_back(8'h04);
    endcase
  endtask

  always @(posedge sd_sck) begin
    sck_rises++;
    if (sd_cs_n && sd_mosi && !first_cs) pre_cnt++;
    if (!sd_cs_n) begin
      rxb = {rxb[6:0], sd_mosi};
      bitn++;
      if (bitn == 8) begin
        bitn = 0;
        if (in_frame) begin
          frame = {frame[39:0], rxb};
          fcnt++;
          if (fcnt == 6) begin
            in_frame = 0;
            card_cmd(frame);
          end
        end else if (rxb[7:6] == 2'b01) begin
          in_frame = 1;
          frame = {40'd0, rxb};
          fcnt = 1;
        end
      end
    end
  end

  always @(negedge sd_sck) begin
    if (!sd_cs_n) begin
      if (bitn == 0) cur = (out_q.size() > 0) ? out_q.pop_front() : 8'hFF;
      else cur = {cur[6:0], 1'b1};
      sd_miso = cur[7];
    end
  end

  always @(negedge sd_cs_n) begin
    if (!first_cs) begin first_cs = 1; pre_at_cs = pre_cnt; end
    bitn = 0;
    cur = (out_q.size() > 0) ? out_q.pop_front() : 8'hFF;
    sd_miso = cur[7];
  end

  always @(posedge sd_cs_n) begin
    out_q.delete();
    bitn = 0;
    in_frame = 0;
    sd_miso = 1'b1;
  end

  // ---------------- per-clock reference checks ----------------
  logic prev_sck  = 1'b0;
  logic prev_mosi = 1'b1;
  int   high_len  = 0;
  bit   started   = 0;

  always @(negedge clk) begin
    if (started) begin
      chk(!(ready && error), "R4 ready/error exclusive", {ready, error}, 2'b00);
      if (prev_sck && sd_sck)
        chk(sd_mosi == prev_mosi, "R6 mosi stable while sck high", sd_mosi, prev_mosi);
      if (sd_sck) high_len++;
      else begin
        if (prev_sck && !sd_cs_n)
          chk(high_len == CLK_DIV, "R6 sck high time", high_len, CLK_DIV);
        high_len = 0;
      end
    end
    prev_sck  = sd_sck;
    prev_mosi = sd_mosi;
  end

  // ---------------- helpers ----------------
  task automatic pulse_init();
    @(negedge clk);
    cmd_log.delete();
    pre_cnt = 0;
    first_cs = 0;
    init_req = 1'b1;
    @(negedge clk);
    init_req = 1'b0;
  endtask

  task automatic pulse_read(input logic [BLK_W-1:0] b);
    @(negedge clk);
    blk_num  = b;
    rd_start = 1'b1;
    @(negedge clk);
    rd_start = 1'b0;
  endtask

  task automatic wait_settle(input string tag);
    int n = 0;
    while (!(ready || error) && n < 60000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 60000) chk(1'b0, {tag, " watchdog"}, n, 0);
  endtask

  function automatic int count_idx(input logic [5:0] idx);
    int c = 0;
    foreach (cmd_log[i]) if (cmd_log[i][45:40] == idx) c++;
    return c;
  endfunction

  initial begin
    #(8 * 190000);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int s;
    int nlog;
    rst = 1'b1; init_req = 1'b0; rd_start = 1'b0; blk_num = '0; byte_idx = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    started = 1;
    chk(sd_cs_n == 1'b1, "R1 cs_n after reset", sd_cs_n, 1);
    chk(sd_sck == 1'b0, "R1 sck after reset", sd_sck, 0);
    chk({ready, error} == 2'b00, "R1 status after reset", {ready, error}, 0);

    // read request before any init is ignored
    pulse_read(23'd3);
    repeat (100) @(negedge clk);
    chk(sck_rises == 0, "R1 R7 no sck before init", sck_rises, 0);
    chk(ready == 1'b0, "R7 read ignored before init", ready, 0);

    // bring-up with three busy replies
    busy_n = 3;
    pulse_init();
    wait_settle("R4 init");
    chk({ready, error} == 2'b10, "R4 ready after busy loop", {ready, error}, 2'b10);
    chk(pre_at_cs >= 74, "R2 power-up clocks", pre_at_cs, 74);
    chk(cmd_log.size() > 0 && cmd_log[0] == 48'h400000000095, "R2 reset frame",
        (cmd_log.size() > 0) ? cmd_log[0] : 48'h0, 48'h400000000095);
    chk(count_idx(6'd41) == 4, "R4 CMD41 count", count_idx(6'd41), 4);
    s = 1;
    for (int i = 1; i < 9; i++)
      if (i >= cmd_log.size() || cmd_log[i][47:40] != ((i % 2 == 1) ? 8'h77 : 8'h69)) s = 0;
    chk(s == 1 && cmd_log.size() == 9, "R4 CMD55/CMD41 pairing", cmd_log.size(), 9);

    // normal read of block 5
    tok_dly = 3;
    cmd_log.delete();
    pulse_read(23'd5);
    chk(ready == 1'b0, "R8 ready drops on read", ready, 0);
    wait_settle("R8 read 5");
    chk({ready, error} == 2'b10, "R8 ready after read", {ready, error}, 2'b10);
    chk(cmd_log.size() == 1 && cmd_log[0] == {8'h51, 32'h00000A00, 8'h01}, "R7 read frame blk 5",
        (cmd_log.size() > 0) ? cmd_log[0] : 48'h0, {8'h51, 32'h00000A00, 8'h01});
    s = 0;
    for (int i = 0; i < 512; i++) begin
      byte_idx = 9'(i);
      @(negedge clk);
      if (byte_out != pat(32'd5, i)) begin
        s++;
        if (s < 4) chk(1'b0, "R8 stored byte", byte_out, pat(32'd5, i));
      end
    end
    chk(s == 0, "R8 all 512 bytes of block 5", s, 0);

    // highest block number
    cmd_log.delete();
    pulse_read({BLK_W{1'b1}});
    wait_settle("R7 read max");
    chk(cmd_log.size() == 1 && cmd_log[0][39:8] == 32'hFFFFFE00, "R7 max block argument",
        (cmd_log.size() > 0) ? cmd_log[0][39:8] : 32'h0, 32'hFFFFFE00);
    byte_idx = 9'd0;   @(negedge clk);
    chk(byte_out == pat(32'h7FFFFF, 0), "R8 byte 0 of max block", byte_out, pat(32'h7FFFFF, 0));
    byte_idx = 9'd511; @(negedge clk);
    chk(byte_out == pat(32'h7FFFFF, 511), "R8 byte 511 of max block", byte_out, pat(32'h7FFFFF, 511));

    // data error token
    tok = 8'h05;
    pulse_read(23'd9);
    wait_settle("R9 error token");
    chk({ready, error} == 2'b01, "R9 error token", {ready, error}, 2'b01);
    tok = 8'hFE;
    nlog = cmd_log.size();
    pulse_read(23'd9);
    repeat (200) @(negedge clk);
    chk(cmd_log.size() == nlog && ready == 1'b0, "R7 read ignored while error", cmd_log.size(), nlog);

    // init clears error
    busy_n = 0;
    pulse_init();
    chk({ready, error} == 2'b00, "R10 init clears error", {ready, error}, 0);
    wait_settle("R10 reinit");
    chk({ready, error} == 2'b10, "R10 ready after reinit", {ready, error}, 2'b10);

    // token timeout
    tok_dly = 100;
    pulse_read(23'd1);
    wait_settle("R9 token timeout");
    chk({ready, error} == 2'b01, "R9 token timeout", {ready, error}, 2'b01);
    tok_dly = 2;

    // bad reset reply
    resp0 = 8'h05;
    pulse_init();
    wait_settle("R3 bad reply");
    chk({ready, error} == 2'b01, "R3 bad reset reply", {ready, error}, 2'b01);
    resp0 = 8'h01;

    // reply on last allowed poll byte, then one too late
    ncr0 = 7;
    pulse_init();
    wait_settle("R5 poll 8");
    chk({ready, error} == 2'b10, "R5 reply on 8th poll", {ready, error}, 2'b10);
    ncr0 = 8;
    pulse_init();
    wait_settle("R5 poll 9");
    chk({ready, error} == 2'b01, "R5 reply on 9th poll", {ready, error}, 2'b01);
    ncr0 = 1;

    // card stays busy
    busy_n = 1000;
    pulse_init();
    wait_settle("R4 busy");
    chk({ready, error} == 2'b01, "R4 busy timeout", {ready, error}, 2'b01);
    chk(count_idx(6'd41) == ACMD_TRIES, "R4 CMD41 attempts", count_idx(6'd41), ACMD_TRIES);
    busy_n = 0;

    // restart during a read
    pulse_init();
    wait_settle("R10 pre");
    pulse_read(23'd2);
    repeat (3000) @(negedge clk);
    pulse_init();
    chk({ready, error} == 2'b00, "R10 init mid-read clears", {ready, error}, 0);
    wait_settle("R10 mid-read");
    chk({ready, error} == 2'b10, "R10 ready after restart", {ready, error}, 2'b10);
    pulse_read(23'd7);
    wait_settle("R10 read 7");
    byte_idx = 9'd100; @(negedge clk);
    chk(byte_out == pat(32'd7, 100), "R10 read after restart", byte_out, pat(32'd7, 100));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule